// File: doc/BRIEF.md
# SCSI Controller Register File

This block is the byte-wide host register interface of a simple SCSI bus controller. A host reaches sixteen 8-bit registers through an address whose bits [5:2] pick the register. Behind them sit a 16-bit transfer count, a byte FIFO, a command register, configuration and scratch registers, and an interrupt path. The command register takes an opcode and a DMA mode flag. The interrupt path keeps an interrupt-cause register, a status register and a sequence-step register, and drives one interrupt line to the host.

Every access takes one cycle. On a write strobe, the write happens at the rising edge. On a read strobe, `rdata` is loaded at the rising edge with the register value as it was before that edge. Any side effect of the read also happens at that edge. If both strobes are high in the same cycle, the write is done and the read is ignored.

Popping a byte from the FIFO raises the interrupt. Reading the interrupt-cause register acknowledges the interrupt. Four opcodes are decoded: no-op, FIFO flush, chip reset and bus reset. A configuration bit can mask the interrupt that a bus reset would raise.

Top module: `scsi_regfile`

## Requirements
- R1: The register index is `addr[5:2]`. Address bits [1:0] and all bits above bit 5 have no effect on which register is accessed.
- R2: Writing index 0 sets the low byte of the transfer count and writing index 1 sets the high byte. Both bytes read back at the same indices.
- R3: A write to index 2 appends the byte to the FIFO when the FIFO is not full. The occupancy count, read at index 7 bits [4:0], goes up by one.
- R4: A read of index 2 on a non-empty FIFO returns the oldest byte and removes it from the FIFO. It also sets `irq` and status (index 4) bit 7. A read of index 2 on an empty FIFO returns the byte from the last successful pop and changes nothing else.
- R5: A pop that empties the FIFO sets status bit 4, the terminal-count bit. Both FIFO pointers then return to zero, so bytes pushed afterwards come out in push order.
- R6: A read of index 5 returns the interrupt cause. It also clears `irq` and every status bit except bit 4.
- R7: A write to index 3 with a known opcode in bits [6:0] stores the value, which reads back at index 3. Bit 7 of the written value drives `dma_mode`. The known opcodes are 0 (no-op), 1 (flush), 2 (chip reset) and 3 (bus reset).
- R8: Flush sets the interrupt cause to 0x08 and the sequence step (index 6) to 0. It clears the overflow flag (index 7 bit 7) and keeps the FIFO contents.
- R9: Bus reset sets the interrupt cause to 0x80. It raises `irq` and status bit 7 only if configuration register index 8 bit 6 is 0.
- R10: Index 11 stores only the bits in mask 0x15. Indices 8 and 12 to 15 store the full byte. Indices 9 and 10 ignore writes and read as 0.
- R11: A write to a full FIFO (16 entries) is dropped and sets the sticky overflow flag.
- R12: A command write with an unknown opcode changes no state. Chip reset clears every register, both pointers, the FIFO count, the overflow flag and `irq`.
- R13: After `rst_n` is asserted, every readable register reads 0 and `irq` and `dma_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address; bits [5:2] form the index |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, loaded at the edge that ends a read |
| irq | output | 1 | Interrupt request to the host |
| dma_mode | output | 1 | DMA flag from the last accepted command |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO, an 8-bit address, mask 0x15 for index 11 and bit 6 as the bus-reset interrupt mask. The address width of 8 gives the bench two address bits above the index to set, so it can show that they are ignored. The 16-entry depth is small enough that random push and pop traffic often reaches both a full and an empty FIFO. Those runs cover dropped writes, overflow, pointer wrap and the rewind of the pointers after a drain, with every popped byte compared against a queue model kept in the bench.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

   localparam int IDX_W = 4;

   // register indices whose decode the logic depends on
   localparam logic [IDX_W-1:0] IX_TC_LO  = 4'd0;
   localparam logic [IDX_W-1:0] IX_TC_HI  = 4'd1;
   localparam logic [IDX_W-1:0] IX_FIFO   = 4'd2;
   localparam logic [IDX_W-1:0] IX_CMD    = 4'd3;
   localparam logic [IDX_W-1:0] IX_STAT   = 4'd4;
   localparam logic [IDX_W-1:0] IX_CAUSE  = 4'd5;
   localparam logic [IDX_W-1:0] IX_STEP   = 4'd6;
   localparam logic [IDX_W-1:0] IX_FLAGS  = 4'd7;
   localparam logic [IDX_W-1:0] IX_CFG_A  = 4'd8;
   localparam logic [IDX_W-1:0] IX_CFG_B  = 4'd11;

   typedef enum logic [6:0] {
      OP_NOP     = 7'd0,
      OP_FLUSH   = 7'd1,
      OP_CHIPRST = 7'd2,
      OP_BUSRST  = 7'd3
   } opcode_e;

   localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
   localparam logic [7:0] CAUSE_BUS_RESET = 8'h80;
   localparam int         STAT_INT_BIT    = 7;
   localparam int         STAT_TC_BIT     = 4;

   typedef struct packed {
      logic nop;
      logic flush;
      logic chip_rst;
      logic bus_rst;
   } cmd_pulse_t;

endpackage

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
   parameter int DEPTH = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          clr_ovf,
   input  logic          push,
   input  logic          pop,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic [CW-1:0] count,
   output logic          ovf,
   output logic          pop_ok,
   output logic          drained
);

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] rptr, wptr;
   logic          full;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("scsi_rf_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   assign full    = (count == CW'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign drained = pop_ok && (count == CW'(1));
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (push && !full && !clr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         wptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         rptr  <= '0;
         wptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (clr_ovf) ovf <= 1'b0;
         if (push) begin
            if (full) begin
               ovf <= 1'b1;
            end else begin
               wptr  <= wptr + PW'(1);
               count <= count + CW'(1);
            end
         end else if (pop_ok) begin
            if (drained) begin
               rptr  <= '0;
               wptr  <= '0;
               count <= '0;
            end else begin
               rptr  <= rptr + PW'(1);
               count <= count - CW'(1);
            end
         end
      end
   end

   a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> (ovf && count == $past(count)));

   a_r3_push_count: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !clr) |=> (count == $past(count) + CW'(1)));

   a_r5_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      (drained && !push && !clr) |=> (rptr == '0 && wptr == '0 && count == '0));

endmodule

// File: rtl/scsi_rf_cmd.sv
module scsi_rf_cmd
   import scsi_rf_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [7:0] cmd_val,
   output logic       known,
   output cmd_pulse_t go
);

   logic [6:0] op;
   assign op = cmd_val[6:0];

   always_comb begin
      go = '0;
      if (cmd_wr) begin
         unique case (op)
            OP_NOP:     go.nop      = 1'b1;
            OP_FLUSH:   go.flush    = 1'b1;
            OP_CHIPRST: go.chip_rst = 1'b1;
            OP_BUSRST:  go.bus_rst  = 1'b1;
            default:    go = '0;
         endcase
      end
   end

   assign known = |go;

endmodule

// File: rtl/scsi_rf_irq.sv
module scsi_rf_irq
   import scsi_rf_pkg::*;
#(
   parameter int MASK_BIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_pulse_t go,
   input  logic       pop_ok,
   input  logic       drained,
   input  logic       ack,
   input  logic [7:0] cfg,
   output logic [7:0] cause,
   output logic [7:0] status,
   output logic [7:0] step,
   output logic       irq
);

   localparam logic [7:0] KEEP_MASK = 8'(1) << STAT_TC_BIT;

   generate
      if (MASK_BIT < 0 || MASK_BIT > 7) begin : g_bad_bit
         $error("scsi_rf_irq: MASK_BIT must select a bit of an 8-bit register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause  <= '0;
         status <= '0;
         step   <= '0;
         irq    <= 1'b0;
      end else if (go.chip_rst) begin
         cause  <= '0;
         status <= '0;
         step   <= '0;
         irq    <= 1'b0;
      end else begin
         if (pop_ok) begin
            irq                  <= 1'b1;
            status[STAT_INT_BIT] <= 1'b1;
            if (drained) status[STAT_TC_BIT] <= 1'b1;
         end
         if (ack) begin
            irq    <= 1'b0;
            status <= status & KEEP_MASK;
         end
         if (go.flush) begin
            cause <= CAUSE_FUNC_DONE;
            step  <= '0;
         end
         if (go.bus_rst) begin
            cause <= CAUSE_BUS_RESET;
            if (!cfg[MASK_BIT]) begin
               irq                  <= 1'b1;
               status[STAT_INT_BIT] <= 1'b1;
            end
         end
      end
   end

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !pop_ok) |=> (!irq && !status[STAT_INT_BIT] &&
                            status[STAT_TC_BIT] == $past(status[STAT_TC_BIT])));

   a_r9_masked_busrst: assert property (@(posedge clk) disable iff (!rst_n)
      (go.bus_rst && cfg[MASK_BIT] && !ack && !pop_ok) |=> (irq == $past(irq)));

   a_r12_chip_reset: assert property (@(posedge clk) disable iff (!rst_n)
      go.chip_rst |=> (!irq && cause == '0 && status == '0));

endmodule

// File: rtl/scsi_regfile.sv
module scsi_regfile
   import scsi_rf_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         FIFO_DEPTH = 16,
   parameter logic [7:0] CFG_B_MASK = 8'h15,
   parameter int         MASK_BIT   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              dma_mode
);

   localparam int CW      = $clog2(FIFO_DEPTH + 1);
   localparam int N_SCR   = 4;
   localparam int SCR_LOW = 12;

   logic [IDX_W-1:0] idx;
   logic             wr, rd, unused_hi;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("scsi_regfile: ADDR_W must cover bits [5:2]");
      end
      if (CW > 5) begin : g_bad_depth
         $error("scsi_regfile: FIFO count must fit bits [4:0] of the flag register");
      end
      if (ADDR_W > 6) begin : g_hi_addr
         assign unused_hi = ^{addr[ADDR_W-1:6], addr[1:0]};
      end else begin : g_no_hi_addr
         assign unused_hi = ^addr[1:0];
      end
   endgenerate

   assign idx = addr[5:2];
   assign wr  = wr_en;
   assign rd  = rd_en && !wr_en;

   // command decode
   cmd_pulse_t go;
   logic       cmd_known;

   scsi_rf_cmd u_cmd (
      .cmd_wr  (wr && idx == IX_CMD),
      .cmd_val (wdata),
      .known   (cmd_known),
      .go      (go)
   );

   // FIFO
   logic [7:0]    fifo_dout, fifo_last;
   logic [CW-1:0] fifo_count;
   logic          fifo_ovf, pop_ok, drained;

   scsi_rf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go.chip_rst),
      .clr_ovf (go.flush),
      .push    (wr && idx == IX_FIFO),
      .pop     (rd && idx == IX_FIFO),
      .din     (wdata),
      .dout    (fifo_dout),
      .count   (fifo_count),
      .ovf     (fifo_ovf),
      .pop_ok  (pop_ok),
      .drained (drained)
   );

   // interrupt, status and sequence step
   logic [7:0] cause, status, step, cfg_a;

   scsi_rf_irq #(.MASK_BIT(MASK_BIT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .pop_ok  (pop_ok),
      .drained (drained),
      .ack     (rd && idx == IX_CAUSE),
      .cfg     (cfg_a),
      .cause   (cause),
      .status  (status),
      .step    (step),
      .irq     (irq)
   );

   // plain storage registers
   logic [7:0] tc_lo, tc_hi, cmd_q, cfg_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_lo     <= '0;
         tc_hi     <= '0;
         cmd_q     <= '0;
         cfg_a     <= '0;
         cfg_b     <= '0;
         fifo_last <= '0;
      end else if (go.chip_rst) begin
         tc_lo     <= '0;
         tc_hi     <= '0;
         cmd_q     <= '0;
         cfg_a     <= '0;
         cfg_b     <= '0;
         fifo_last <= '0;
      end else begin
         if (wr && idx == IX_TC_LO) tc_lo <= wdata;
         if (wr && idx == IX_TC_HI) tc_hi <= wdata;
         if (cmd_known)             cmd_q <= wdata;
         if (wr && idx == IX_CFG_A) cfg_a <= wdata;
         if (wr && idx == IX_CFG_B) cfg_b <= wdata & CFG_B_MASK;
         if (pop_ok)                fifo_last <= fifo_dout;
      end
   end

   logic [7:0] scratch [N_SCR];

   generate
      for (genvar g = 0; g < N_SCR; g++) begin : g_scratch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   scratch[g] <= '0;
            else if (go.chip_rst)                         scratch[g] <= '0;
            else if (wr && idx == IDX_W'(SCR_LOW + g))    scratch[g] <= wdata;
         end
      end
   endgenerate

   assign dma_mode = cmd_q[7];

   // read path
   logic [7:0] rd_mux, flags;
   assign flags = 8'(fifo_count) | {fifo_ovf, 7'b0};

   always_comb begin
      unique case (idx)
         IX_TC_LO:  rd_mux = tc_lo;
         IX_TC_HI:  rd_mux = tc_hi;
         IX_FIFO:   rd_mux = (fifo_count != '0) ? fifo_dout : fifo_last;
         IX_CMD:    rd_mux = cmd_q;
         IX_STAT:   rd_mux = status;
         IX_CAUSE:  rd_mux = cause;
         IX_STEP:   rd_mux = step;
         IX_FLAGS:  rd_mux = flags;
         IX_CFG_A:  rd_mux = cfg_a;
         IX_CFG_B:  rd_mux = cfg_b;
         4'd12, 4'd13, 4'd14, 4'd15: rd_mux = scratch[idx[1:0]];
         default:   rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_mux;
   end

   a_r4_pop_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && idx == IX_FIFO && fifo_count != '0) |=> irq);

   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (idx == 4'd9 || idx == 4'd10)) |=> (rdata == 8'h00));

   a_r7_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IX_CMD && wdata[6:0] <= 7'd3 && wdata[6:0] != 7'd2)
         |=> (dma_mode == $past(wdata[7])));

   a_r12_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && idx == IX_CMD && wdata[6:0] > 7'd3) |=> (cmd_q == $past(cmd_q)));

endmodule

// File: tb/test_scsi_regfile.sv
module test_scsi_regfile;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, dma_mode;

   int tests = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   scsi_regfile i_scsi_regfile (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .irq(irq), .dma_mode(dma_mode)
   );

   function automatic logic [7:0] ra(input int n);
      return 8'(n * 4);
   endfunction

   function automatic logic [7:0] flags_of(input bit ovf, input int cnt);
      return {ovf, 2'b00, 5'(cnt)};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic rdchk(input string req, input int n, input logic [7:0] exp);
      logic [7:0] v;
      rd(ra(n), v);
      chk(req, v, exp);
   endtask

   logic [7:0] mq[$];
   bit         m_ovf;
   logic [7:0] m_last;

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      chk("R13 irq", {7'b0, irq}, 8'h00);
      chk("R13 dma_mode", {7'b0, dma_mode}, 8'h00);
      rdchk("R13 cause", 5, 8'h00);
      rdchk("R13 flags", 7, 8'h00);
      rdchk("R13 cmd", 3, 8'h00);
      rdchk("R13 status", 4, 8'h00);

      // R2 transfer count
      wr(ra(0), 8'h5A); wr(ra(1), 8'hC3);
      rdchk("R2 tc low", 0, 8'h5A);
      rdchk("R2 tc high", 1, 8'hC3);

      // R1 address bits outside [5:2] ignored
      wr(8'hC0 | ra(12) | 8'h03, 8'h6E);
      rdchk("R1 high addr bits", 12, 8'h6E);
      rd(8'h80 | ra(0) | 8'h01, v); chk("R1 alias read", v, 8'h5A);

      // R10 masked, stored and reserved registers
      wr(ra(11), 8'hFF); rdchk("R10 mask 0x15", 11, 8'h15);
      wr(ra(8), 8'h40);  rdchk("R10 cfg8", 8, 8'h40);
      wr(ra(15), 8'hA5); rdchk("R10 scratch15", 15, 8'hA5);
      wr(ra(9), 8'hFF);  rdchk("R10 reg9 ignored", 9, 8'h00);
      wr(ra(10), 8'h77); rdchk("R10 reg10 ignored", 10, 8'h00);
      wr(ra(8), 8'h00);

      // R3/R4/R5 push, pop, drain
      wr(ra(2), 8'h11); wr(ra(2), 8'h22); wr(ra(2), 8'h33);
      rdchk("R3 count 3", 7, flags_of(0, 3));
      rdchk("R4 pop 1", 2, 8'h11);
      chk("R4 irq after pop", {7'b0, irq}, 8'h01);
      rdchk("R4 pop 2", 2, 8'h22);
      rdchk("R4 pop 3", 2, 8'h33);
      rdchk("R5 status int+tc", 4, 8'h90);
      rdchk("R6 cause read", 5, 8'h00);
      chk("R6 irq cleared", {7'b0, irq}, 8'h00);
      rdchk("R6 status keeps tc", 4, 8'h10);
      rdchk("R4 empty pop repeats", 2, 8'h33);
      chk("R4 empty pop no irq", {7'b0, irq}, 8'h00);
      rdchk("R5 count 0", 7, 8'h00);

      // R11 overflow
      for (int i = 0; i < 17; i++) wr(ra(2), 8'(8'h40 + i));
      rdchk("R11 full + ovf", 7, flags_of(1, 16));
      rdchk("R11 first byte kept", 2, 8'h40);

      // R8 flush
      wr(ra(3), 8'h01);
      rdchk("R8 cause 0x08", 5, 8'h08);
      rdchk("R8 step 0", 6, 8'h00);
      rdchk("R8 ovf cleared, count kept", 7, flags_of(0, 15));

      // R7 dma flag and readback
      wr(ra(3), 8'h81);
      chk("R7 dma on", {7'b0, dma_mode}, 8'h01);
      rdchk("R7 cmd readback", 3, 8'h81);
      wr(ra(3), 8'h00);
      chk("R7 dma off", {7'b0, dma_mode}, 8'h00);

      // R12 unknown opcode
      wr(ra(3), 8'h90);
      rdchk("R12 unknown keeps cmd", 3, 8'h00);
      chk("R12 unknown keeps dma", {7'b0, dma_mode}, 8'h00);
      rdchk("R12 unknown keeps fifo", 7, flags_of(0, 15));

      // R9 bus reset with and without mask
      wr(ra(8), 8'h40); wr(ra(3), 8'h03);
      chk("R9 masked no irq", {7'b0, irq}, 8'h00);
      rdchk("R9 cause 0x80", 5, 8'h80);
      wr(ra(8), 8'h00); wr(ra(3), 8'h03);
      chk("R9 unmasked irq", {7'b0, irq}, 8'h01);
      rdchk("R9 status int", 4, 8'h90);

      // R12 chip reset
      wr(ra(11), 8'h05);
      wr(ra(3), 8'h02);
      chk("R12 chip reset irq", {7'b0, irq}, 8'h00);
      rdchk("R12 tc low", 0, 8'h00);
      rdchk("R12 flags", 7, 8'h00);
      rdchk("R12 cfg11", 11, 8'h00);
      rdchk("R12 scratch12", 12, 8'h00);
      rdchk("R12 cause", 5, 8'h00);
      rdchk("R12 status", 4, 8'h00);

      // random push/pop against a queue model (R3 R4 R5 R11)
      mq.delete(); m_ovf = 0; m_last = 8'h00;
      for (int k = 0; k < 600; k++) begin
         int sel;
         sel = int'($urandom % 8);
         if (sel < 4) begin
            logic [7:0] b;
            b = 8'($urandom);
            wr(ra(2), b);
            if (mq.size() < 16) mq.push_back(b); else m_ovf = 1;
         end else if (sel < 7) begin
            logic [7:0] e;
            bit had;
            had = (mq.size() > 0);
            if (had) begin e = mq.pop_front(); m_last = e; end else e = m_last;
            rd(ra(2), v);
            chk("R4 random pop data", v, e);
            if (had) chk("R4 random pop irq", {7'b0, irq}, 8'h01);
         end else begin
            rdchk("R11 random flags", 7, flags_of(m_ovf, mq.size()));
            rd(ra(5), v);
         end
      end
      rdchk("R3 final flags", 7, flags_of(m_ovf, mq.size()));

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule